// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level translation table that lives in memory. Software loads a root register with the frame number of the top-level table, called the directory. Each walk starts from that root. The walker reads one directory entry, then one second-level entry, and then reports either the physical address or a fault that names the level which failed.

Each table is one 4 KB page of 1024 entries of four bytes each. One second-level table therefore maps 4 MB, and a single directory maps the whole 4 GB space. The virtual address is split into three fields:

- bits [31:22] select the directory entry;
- bits [21:12] select the second-level entry;
- bits [11:0] are the byte offset within the page, carried through unchanged.

An entry holds a frame number in bits [31:12] and a valid flag in bit 0.

The walker has a simple memory read port with one read outstanding at a time. It raises a request with a word address and holds both until memory returns a response. Only one walk is in flight at a time. The walker takes a new request only while it is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req`, `done_valid` and `fault` are 0.
- R2: In the cycle after a request is accepted, `mem_req` is 1 and `mem_addr` is `{root[19:0], va[31:22], 2'b00}`, where `root` is the root value held when the request was accepted.
- R3: After a directory entry with bit 0 set is returned, the next read goes to `{entry[31:12], va[21:12], 2'b00}`.
- R4: While a read is waiting, `mem_req` stays 1 and `mem_addr` stays unchanged until `mem_rsp_valid` is seen.
- R5: When a second-level entry with bit 0 set is returned, `done_valid` pulses for exactly one cycle, in the next cycle. In that cycle `done_paddr` is `{entry[31:12], va[11:0]}`.
- R6: When a directory entry with bit 0 clear is returned, `fault` pulses for one cycle with `fault_level` 0, and no second read is issued.
- R7: When a second-level entry with bit 0 clear is returned, `fault` pulses for one cycle with `fault_level` 1, and `done_valid` stays 0.
- R8: Entry bits [11:1] have no effect on addresses, results or validity.
- R9: `req_ready` is 0 from the cycle after acceptance until the end of the result cycle. Requests made while it is 0 are ignored.
- R10: A root write while a walk is in progress does not change that walk. The next walk uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Load the root register |
| root_wdata | input | 20 | Frame number of the directory |
| req_valid | input | 1 | Walk request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle; a request is taken this cycle |
| mem_req | output | 1 | Memory read pending |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word |
| done_valid | output | 1 | Translation complete (one cycle) |
| done_paddr | output | 32 | Physical address |
| fault | output | 1 | Translation failed (one cycle) |
| fault_level | output | 1 | 0: directory entry invalid, 1: second-level entry invalid |

## Verification
Walks are run in four patterns:

- A walk whose memory responds at once confirms the two entry addresses and the joined result.
- A walk with stalled responses shows that the request and address are held while waiting.
- Walks with an invalid entry at each level show that the reported fault level follows the failing read, and that a directory fault issues no second read.
- Entries with noise in their low bits, requests made while busy, and a root write during a walk show that none of these leak into the current translation.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    root_we,
  input  logic [ADDR_W-OFS_W-1:0] root_wdata,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_vaddr,
  output logic                    req_ready,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic                    mem_rsp_valid,
  input  logic [ADDR_W-1:0]       mem_rsp_data,
  output logic                    done_valid,
  output logic [ADDR_W-1:0]       done_paddr,
  output logic                    fault,
  output logic                    fault_level
);
  localparam int FRAME_W = ADDR_W - OFS_W;
  localparam int ENT_B   = OFS_W - IDX_W;

  typedef enum logic [2:0] {S_IDLE, S_DIR, S_PT, S_DONE, S_FLT} st_t;

  st_t                st;
  logic [FRAME_W-1:0] root, frame;
  logic [ADDR_W-1:0]  va, ent_addr;
  logic               lvl;

  wire [FRAME_W-1:0] rsp_frame = mem_rsp_data[ADDR_W-1:OFS_W];
  wire               rsp_ok    = mem_rsp_data[0];

  logic unused_bits;
  assign unused_bits = ^mem_rsp_data[OFS_W-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      root     <= '0;
      frame    <= '0;
      va       <= '0;
      ent_addr <= '0;
      lvl      <= 1'b0;
    end else begin
      if (root_we) root <= root_wdata;
      case (st)
        S_IDLE: if (req_valid) begin
          va       <= req_vaddr;
          ent_addr <= {root, req_vaddr[ADDR_W-1 -: IDX_W], {ENT_B{1'b0}}};
          st       <= S_DIR;
        end
        S_DIR: if (mem_rsp_valid) begin
          if (rsp_ok) begin
            ent_addr <= {rsp_frame, va[OFS_W+IDX_W-1 -: IDX_W], {ENT_B{1'b0}}};
            st       <= S_PT;
          end else begin
            lvl <= 1'b0;
            st  <= S_FLT;
          end
        end
        S_PT: if (mem_rsp_valid) begin
          if (rsp_ok) begin
            frame <= rsp_frame;
            st    <= S_DONE;
          end else begin
            lvl <= 1'b1;
            st  <= S_FLT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == S_IDLE);
  assign mem_req     = (st == S_DIR) || (st == S_PT);
  assign mem_addr    = ent_addr;
  assign done_valid  = (st == S_DONE);
  assign done_paddr  = {frame, va[OFS_W-1:0]};
  assign fault       = (st == S_FLT);
  assign fault_level = lvl;

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rsp_valid |=> mem_req && $stable(mem_addr));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready && mem_req);

  p_dir_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DIR) && mem_rsp_valid && !rsp_ok |=> fault && !fault_level && !mem_req);

  p_pt_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PT) && mem_rsp_valid && !rsp_ok |=> fault && fault_level && !done_valid);

  p_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PT) && mem_rsp_valid && rsp_ok |=>
      done_valid && done_paddr[ADDR_W-1:OFS_W] == $past(mem_rsp_data[ADDR_W-1:OFS_W]));

  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid || fault |=> req_ready && !done_valid && !fault);
endmodule

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        root_we = 1'b0;
  logic [19:0] root_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, mem_req, done_valid, fault, fault_level;
  logic [31:0] mem_addr, done_paddr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  logic [19:0] cur_root;

  always #2.5 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done_valid(done_valid), .done_paddr(done_paddr),
    .fault(fault), .fault_level(fault_level)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_root(input logic [19:0] r);
    @(negedge clk);
    root_we = 1'b1; root_wdata = r;
    @(negedge clk);
    root_we = 1'b0;
    cur_root = r;
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] pde, input logic [31:0] pte,
                      input int d1, input int d2, input bit noise, input bit rebase,
                      input logic [19:0] nb);
    logic [31:0] dexp = {cur_root, va[31:22], 2'b00};
    logic [31:0] pexp = {pde[31:12], va[21:12], 2'b00};
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 busy after accept", {31'd0, req_ready}, 32'd0);
    chk(mem_req && mem_addr == dexp, "R2 directory entry address", mem_addr, dexp);
    for (int i = 0; i < d1; i++) begin
      if (noise) begin req_valid = 1'b1; req_vaddr = ~va; end
      if (rebase && i == 0) begin root_we = 1'b1; root_wdata = nb; end
      @(negedge clk);
      req_valid = 1'b0; root_we = 1'b0;
      if (rebase && i == 0) cur_root = nb;
      chk(mem_req && mem_addr == dexp, "R4 R9 R10 directory read held", mem_addr, dexp);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = pde;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    if (!pde[0]) begin
      chk(fault && !fault_level && !mem_req, "R6 directory fault",
          {29'd0, mem_req, fault, fault_level}, 32'd2);
    end else begin
      chk(mem_req && mem_addr == pexp, "R3 R8 table entry address", mem_addr, pexp);
      for (int j = 0; j < d2; j++) begin
        if (noise) begin req_valid = 1'b1; req_vaddr = ~va; end
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_req && mem_addr == pexp, "R4 R9 table read held", mem_addr, pexp);
      end
      mem_rsp_valid = 1'b1; mem_rsp_data = pte;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pte[0])
        chk(done_valid && !fault && done_paddr == {pte[31:12], va[11:0]},
            "R5 R8 R10 physical address", done_paddr, {pte[31:12], va[11:0]});
      else
        chk(fault && fault_level && !done_valid, "R7 table fault",
            {30'd0, fault, fault_level}, 32'd3);
    end
    @(negedge clk);
    chk(req_ready && !done_valid && !fault && !mem_req, "R5 R9 single-cycle result",
        {28'd0, req_ready, done_valid, fault, mem_req}, 32'h8);
  endtask

  initial begin
    cur_root = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req && !done_valid && !fault, "R1 reset state",
        {28'd0, req_ready, mem_req, done_valid, fault}, 32'h8);
    rst_n = 1'b1;
    set_root(20'h12345);
    walk(32'hABCD_E123, 32'h0007_7001, 32'h5555_5001, 0, 0, 1'b0, 1'b0, 20'h0);
    walk(32'h0040_1FFF, 32'h0A0B_0FFF, 32'hFEDC_BFFF, 3, 2, 1'b0, 1'b0, 20'h0);
    walk(32'hFFC0_0004, 32'h1234_5FFE, 32'h0, 1, 0, 1'b0, 1'b0, 20'h0);
    walk(32'h8000_2345, 32'h0000_1001, 32'hBEEF_0FFE, 0, 2, 1'b0, 1'b0, 20'h0);
    walk(32'h1357_9BDF, 32'h2222_2001, 32'h3333_3001, 2, 3, 1'b1, 1'b0, 20'h0);
    walk(32'h0123_4567, 32'h4444_4001, 32'h6666_6001, 2, 1, 1'b0, 1'b1, 20'h9ABCD);
    walk(32'h0123_4567, 32'h7777_7001, 32'h8888_8001, 0, 0, 1'b0, 1'b0, 20'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule